// File: doc/BRIEF.md
# Thread-Mode Register File

This block is an integer register file with four read ports and two write ports, built from two physical storage copies, A and B. A run-time mode input chooses how the two copies are shared among hardware threads.

With a single thread, every write lands in both copies. Read ports 0 and 1 look up copy A, and read ports 2 and 3 look up copy B. The thread therefore sees one copy's worth of registers through four read ports, while each copy only has to drive two of them. With two threads, each thread owns one whole copy. With four threads, each copy is cut into an upper half and a lower half, and each half belongs to one thread. This doubles the thread count without adding storage.

In the multi-thread modes, a thread can only use the two read ports wired to its own copy. A read that reaches outside the reader's partition returns zero and raises a per-port error flag. Read data is registered and arrives one cycle after the address. A write becomes visible to reads on the cycle after it is issued. There is no same-cycle bypass. Register contents are not carried across a mode change. Software reloads them.

Top module: `tmode_regfile`

## Requirements
- R1: The `mode` input is decoded as follows: 2'b00 is one thread, 2'b01 is two threads, and 2'b10 or 2'b11 is four threads. `mode` may change only in a cycle where every `wr_en` bit is low.
- R2: In one-thread mode, a write is stored in both copies, so the same index read on any of the four read ports returns the same data.
- R3: In one-thread mode, the read thread ID is ignored and `rd_err` stays low on every port.
- R4: In two-thread mode, thread ID bit 0 selects the copy: 0 selects A (ports 0–1) and 1 selects B (ports 2–3). Threads 0 and 1 each hold their own value at the same index.
- R5: In two- or four-thread mode, a read on a port whose copy differs from thread ID bit 0 returns zero with `rd_err` set.
- R6: In four-thread mode, a thread's physical row is {thread ID bit 1, index bits 3:0}. The four threads each keep 16 private registers.
- R7: In four-thread mode, an index of 16 or more (index bit 4 set) reads as zero with `rd_err` set. A write to such an index is dropped and changes no register.
- R8: Read data and `rd_err` appear on the cycle after the address is presented. A read of a register in the same cycle as a write to it returns the old value, and the next read returns the new one.
- R9: When both write ports target the same physical row of a copy in the same cycle, write port 1's data is kept.
- R10: Synchronous reset clears every `rd_data` lane and every `rd_err` bit.
- R11: Whenever `rd_err` is set on a port, that port's `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Thread mode select |
| wr_en | input | 2 | Write enable for each write port |
| wr_tid | input | 4 | Thread ID for each write port, 2 bits per port |
| wr_idx | input | 10 | Register index for each write port, 5 bits per port |
| wr_data | input | 64 | Write data, 32 bits per port |
| rd_tid | input | 8 | Thread ID for each read port, 2 bits per port |
| rd_idx | input | 20 | Register index for each read port, 5 bits per port |
| rd_data | output | 128 | Registered read data, 32 bits per port |
| rd_err | output | 4 | Registered partition-violation flag for each read port |

## Verification
The checker watches four things on every cycle:
- The error flag forces zero data.
- The error flag is never raised in one-thread mode.
- A cross-copy read raises the flag in the multi-thread modes.
- An upper-half index raises the flag in four-thread mode.

The checker also confirms that `mode` only changes while the write ports are idle. The following behaviours depend on stored contents, so only the bench's scenarios show them:
- mirroring of writes into both copies
- per-thread isolation in two-thread and four-thread modes
- dropping of out-of-range writes
- read-before-write timing
- write-port priority

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;
  typedef enum logic [1:0] {
    TM_SOLO  = 2'b00,
    TM_PAIR  = 2'b01,
    TM_QUAD  = 2'b10,
    TM_QUAD2 = 2'b11
  } tmode_e;

  function automatic logic mode_is_solo(input logic [1:0] m);
    return m == TM_SOLO;
  endfunction

  function automatic logic mode_is_quad(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/tmrf_wr_steer.sv
module tmrf_wr_steer
  import tmrf_pkg::*;
#(
  parameter int IW = 5,
  parameter int TW = 2
) (
  input  logic [1:0]    mode,
  input  logic          en,
  input  logic [TW-1:0] tid,
  input  logic [IW-1:0] idx,
  output logic          en_a,
  output logic          en_b,
  output logic [IW-1:0] row
);
  logic solo, quad, outside;

  always_comb begin
    solo    = mode_is_solo(mode);
    quad    = mode_is_quad(mode);
    outside = quad & idx[IW-1];
    row     = quad ? {tid[1], idx[IW-2:0]} : idx;
    en_a    = en & ~outside & (solo | ~tid[0]);
    en_b    = en & ~outside & (solo |  tid[0]);
  end
endmodule

// File: rtl/tmrf_rd_check.sv
module tmrf_rd_check
  import tmrf_pkg::*;
#(
  parameter int IW   = 5,
  parameter int TW   = 2,
  parameter bit COPY = 1'b0
) (
  input  logic [1:0]    mode,
  input  logic [TW-1:0] tid,
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] row,
  output logic          err
);
  logic solo, quad;

  always_comb begin
    solo = mode_is_solo(mode);
    quad = mode_is_quad(mode);
    row  = quad ? {tid[1], idx[IW-2:0]} : idx;
    err  = ~solo & ((tid[0] != COPY) | (quad & idx[IW-1]));
  end
endmodule

// File: rtl/tmrf_bank.sv
module tmrf_bank #(
  parameter int NROW = 32,
  parameter int DW   = 32,
  parameter int NWP  = 2,
  parameter int NRP  = 2,
  localparam int AW  = $clog2(NROW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NWP-1:0]    we,
  input  logic [NWP*AW-1:0] waddr,
  input  logic [NWP*DW-1:0] wdata,
  input  logic [NRP*AW-1:0] raddr,
  input  logic [NRP-1:0]    rkill,
  output logic [NRP*DW-1:0] rdata
);
  logic [DW-1:0] mem [NROW];

  // later ports overwrite earlier ones in the same cycle
  always_ff @(posedge clk) begin
    for (int w = 0; w < NWP; w++) begin
      if (we[w]) mem[waddr[w*AW +: AW]] <= wdata[w*DW +: DW];
    end
  end

  // read-first: old contents are returned on a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      for (int r = 0; r < NRP; r++) begin
        rdata[r*DW +: DW] <= rkill[r] ? '0 : mem[raddr[r*AW +: AW]];
      end
    end
  end
endmodule

// File: rtl/tmode_regfile.sv
module tmode_regfile
  import tmrf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 4,
  parameter int NWR  = 2,
  parameter int TW   = 2,
  localparam int IW   = $clog2(NREG),
  localparam int NRDH = NRD / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*TW-1:0] wr_tid,
  input  logic [NWR*IW-1:0] wr_idx,
  input  logic [NWR*DW-1:0] wr_data,
  input  logic [NRD*TW-1:0] rd_tid,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*DW-1:0] rd_data,
  output logic [NRD-1:0]    rd_err
);
  logic [NWR-1:0]    wen_a, wen_b;
  logic [NWR*IW-1:0] wrow;
  logic [NRD*IW-1:0] rrow;
  logic [NRD-1:0]    rerr;

  for (genvar w = 0; w < NWR; w++) begin : g_wr
    tmrf_wr_steer #(.IW(IW), .TW(TW)) u_steer (
      .mode (mode),
      .en   (wr_en[w]),
      .tid  (wr_tid[w*TW +: TW]),
      .idx  (wr_idx[w*IW +: IW]),
      .en_a (wen_a[w]),
      .en_b (wen_b[w]),
      .row  (wrow[w*IW +: IW])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    tmrf_rd_check #(.IW(IW), .TW(TW), .COPY(r >= NRDH)) u_chk (
      .mode (mode),
      .tid  (rd_tid[r*TW +: TW]),
      .idx  (rd_idx[r*IW +: IW]),
      .row  (rrow[r*IW +: IW]),
      .err  (rerr[r])
    );
  end

  tmrf_bank #(.NROW(NREG), .DW(DW), .NWP(NWR), .NRP(NRDH)) u_copy_a (
    .clk   (clk),
    .rst   (rst),
    .we    (wen_a),
    .waddr (wrow),
    .wdata (wr_data),
    .raddr (rrow[0 +: NRDH*IW]),
    .rkill (rerr[0 +: NRDH]),
    .rdata (rd_data[0 +: NRDH*DW])
  );

  tmrf_bank #(.NROW(NREG), .DW(DW), .NWP(NWR), .NRP(NRDH)) u_copy_b (
    .clk   (clk),
    .rst   (rst),
    .we    (wen_b),
    .waddr (wrow),
    .wdata (wr_data),
    .raddr (rrow[NRDH*IW +: NRDH*IW]),
    .rkill (rerr[NRDH +: NRDH]),
    .rdata (rd_data[NRDH*DW +: NRDH*DW])
  );

  always_ff @(posedge clk) begin
    if (rst) rd_err <= '0;
    else     rd_err <= rerr;
  end
endmodule

// File: rtl/tmrf_checks.sv
module tmrf_checks #(
  parameter int NRD = 4,
  parameter int NWR = 2,
  parameter int DW  = 32,
  parameter int TW  = 2,
  parameter int IW  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [NWR-1:0]    wr_en,
  input logic [NRD*TW-1:0] rd_tid,
  input logic [NRD*IW-1:0] rd_idx,
  input logic [NRD*DW-1:0] rd_data,
  input logic [NRD-1:0]    rd_err
);
  // R1
  mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> (wr_en == '0));

  for (genvar p = 0; p < NRD; p++) begin : g_port
    localparam bit COPY = (p >= NRD / 2);

    // R11
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rd_err[p] |-> (rd_data[p*DW +: DW] == '0));

    // R3
    solo_clean_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(mode) == 2'b00) |-> !rd_err[p]);

    // R5
    cross_copy_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(mode) != 2'b00 && $past(rd_tid[p*TW]) != COPY)
      |-> rd_err[p]);

    // R7
    quad_range_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(mode[1]) && $past(rd_idx[p*IW + IW - 1]))
      |-> rd_err[p]);
  end
endmodule

bind tmode_regfile tmrf_checks #(
  .NRD(NRD), .NWR(NWR), .DW(DW), .TW(TW), .IW(IW)
) u_tmrf_checks (
  .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en),
  .rd_tid(rd_tid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/tmode_regfile_test.sv
module tmode_regfile_test;
  localparam int DW = 32, NRD = 4, NWR = 2, TW = 2, IW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst;
  logic [1:0]        mode;
  logic [NWR-1:0]    wr_en;
  logic [NWR*TW-1:0] wr_tid;
  logic [NWR*IW-1:0] wr_idx;
  logic [NWR*DW-1:0] wr_data;
  logic [NRD*TW-1:0] rd_tid;
  logic [NRD*IW-1:0] rd_idx;
  logic [NRD*DW-1:0] rd_data;
  logic [NRD-1:0]    rd_err;

  tmode_regfile uut (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_tid(wr_tid),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_tid(rd_tid), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  int nvec = 0;
  int nbad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_wr(input int wp, input logic [1:0] tid, input logic [4:0] idx,
                        input logic [31:0] d);
    wr_en[wp]            = 1'b1;
    wr_tid[wp*TW +: TW]  = tid;
    wr_idx[wp*IW +: IW]  = idx;
    wr_data[wp*DW +: DW] = d;
  endtask

  task automatic wr1(input int wp, input logic [1:0] tid, input logic [4:0] idx,
                     input logic [31:0] d);
    @(negedge clk);
    set_wr(wp, tid, idx, d);
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic expect_rd(input string req, input int p, input logic [1:0] tid,
                           input logic [4:0] idx, input logic [31:0] ed, input logic ee);
    @(negedge clk);
    rd_tid[p*TW +: TW] = tid;
    rd_idx[p*IW +: IW] = idx;
    @(negedge clk);
    chk(req, rd_data[p*DW +: DW], ed);
    chk(req, {31'd0, rd_err[p]}, {31'd0, ee});
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 data", rd_data[31:0] | rd_data[63:32] | rd_data[95:64] | rd_data[127:96], '0);
    chk("R10 err", {28'd0, rd_err}, '0);
    rst = 1'b0;
  endtask

  task automatic t_mirror;
    wr1(0, 2'd0, 5'd5, 32'h1111_0005);
    for (int p = 0; p < NRD; p++) expect_rd("R2 mirror", p, 2'd0, 5'd5, 32'h1111_0005, 1'b0);
    expect_rd("R3 tid ignored", 2, 2'd3, 5'd5, 32'h1111_0005, 1'b0);
  endtask

  task automatic t_timing;
    wr1(0, 2'd0, 5'd7, 32'hAAAA_0007);
    @(negedge clk);
    set_wr(0, 2'd0, 5'd7, 32'hBBBB_0007);
    rd_tid[1*TW +: TW] = 2'd0;
    rd_idx[1*IW +: IW] = 5'd7;
    @(negedge clk);
    wr_en = '0;
    chk("R8 old value", rd_data[1*DW +: DW], 32'hAAAA_0007);
    @(negedge clk);
    chk("R8 new value", rd_data[1*DW +: DW], 32'hBBBB_0007);
  endtask

  task automatic t_priority;
    @(negedge clk);
    set_wr(0, 2'd0, 5'd9, 32'h0000_0011);
    set_wr(1, 2'd0, 5'd9, 32'h0000_0022);
    @(negedge clk);
    wr_en = '0;
    expect_rd("R9 port1 wins", 0, 2'd0, 5'd9, 32'h0000_0022, 1'b0);
    expect_rd("R9 port1 wins", 3, 2'd0, 5'd9, 32'h0000_0022, 1'b0);
  endtask

  task automatic t_pair;
    set_mode(2'b01);
    wr1(0, 2'd0, 5'd3, 32'h0D0D_0003);
    wr1(1, 2'd1, 5'd3, 32'h1E1E_0003);
    expect_rd("R4 thread0", 0, 2'd0, 5'd3, 32'h0D0D_0003, 1'b0);
    expect_rd("R4 thread1", 2, 2'd1, 5'd3, 32'h1E1E_0003, 1'b0);
    expect_rd("R5 R11 cross A", 1, 2'd1, 5'd3, 32'h0, 1'b1);
    expect_rd("R5 R11 cross B", 3, 2'd0, 5'd3, 32'h0, 1'b1);
  endtask

  task automatic t_quad;
    set_mode(2'b10);
    for (int t = 0; t < 4; t++) wr1(t % 2, 2'(t), 5'd2, 32'hC0DE_0000 + t);
    for (int t = 0; t < 4; t++)
      expect_rd("R6 private half", (t % 2) * 2 + (t / 2), 2'(t), 5'd2, 32'hC0DE_0000 + t, 1'b0);
    expect_rd("R7 read range", 1, 2'd0, 5'd18, 32'h0, 1'b1);
    expect_rd("R5 quad cross", 0, 2'd1, 5'd2, 32'h0, 1'b1);
    wr1(0, 2'd0, 5'd18, 32'hDEAD_BEEF);
    expect_rd("R7 write dropped", 0, 2'd0, 5'd2, 32'hC0DE_0000, 1'b0);
    expect_rd("R7 write dropped", 1, 2'd2, 5'd2, 32'hC0DE_0002, 1'b0);
  endtask

  task automatic t_alt_mode;
    set_mode(2'b11);
    expect_rd("R1 mode 11 is quad", 0, 2'd2, 5'd2, 32'hC0DE_0002, 1'b0);
    expect_rd("R1 mode 11 range", 2, 2'd3, 5'd20, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    mode = 2'b00; wr_en = '0; wr_tid = '0; wr_idx = '0; wr_data = '0;
    rd_tid = '0; rd_idx = '0; rst = 1'b1;
    t_reset();
    t_mirror();
    t_timing();
    t_priority();
    t_pair();
    t_quad();
    t_alt_mode();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule